// File: doc/BRIEF.md
# Multilevel Interrupt Priority Controller

This controller sits between a bank of peripheral interrupt lines and a CPU. Each line carries a request bit and a two-bit level tag: none, low, medium or high. Each cycle the controller looks at every request whose level is enabled and picks one winner. It holds that winner as a pending vector index until the CPU acknowledges it. Across levels the higher level always wins. Inside the medium and high levels the smallest index wins.

Low-level requests can rotate instead. A software-visible pointer names the low vector that was served last. While rotation is in force, the search starts just above that pointer and wraps around, so the vector served last ranks lowest. When rotation is switched off, the pointer keeps its value. The rotated order therefore stays until software writes zero to the pointer.

Software sees two byte-wide registers on a simple write/read bus. The first is a control byte with the level enables, the rotation enable and a vector-base select. The second is the pointer. A peripheral is expected to drop its request when the CPU acknowledges it.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the control byte (regAddr=0) and the pointer (regAddr=1) both read 0x00, irqPending is 0 and vecBase equals APP_BASE.
- R2: Control bit 2 enables the high level, bit 1 the medium level and bit 0 the low level. Level codes on irqLvl are 1 for low, 2 for medium, 3 for high and 0 for none. A request whose level is disabled is never selected and does not raise irqPending.
- R3: A pending high request beats any medium one, and a pending medium request beats any low one.
- R4: Among high or among medium requests, the lowest index wins, whatever the rotation setting.
- R5: With control bit 7 clear and the pointer at zero, low requests are served lowest index first.
- R6: With control bit 7 set, acknowledging a low vector loads its index into the pointer. The next low pick is the first requesting index above the pointer, wrapping to the lowest requesting index when none lies above.
- R7: Clearing bit 7 leaves the pointer unchanged, and the rotated low order stays in force until zero is written to the pointer.
- R8: vecBase equals BOOT_BASE while control bit 6 is set and APP_BASE while it is clear.
- R9: Control bits 5:3 always read zero, and writing them has no effect on the other bits.
- R10: Once irqPending is raised, irqVector holds until irqAck. This holds even if a higher request arrives in the meantime. The cycle after an acknowledge, irqPending is low, and the next winner is loaded on the following edge.
- R11: An acknowledge with bit 7 clear, or of a medium or high vector, leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the control byte, 1 selects the pointer |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the register at regAddr |
| irqReq | input | NUM_IRQ | Request lines |
| irqLvl | input | 2*NUM_IRQ | Level tag per line, two bits each |
| irqAck | input | 1 | CPU acknowledge of the pending vector |
| irqPending | output | 1 | A selected vector awaits service |
| irqVector | output | $clog2(NUM_IRQ) | Selected vector index |
| vecBase | output | VB_W | Vector base address |

## Verification
A corrupted pointer does not show at once. It shows only on the next arbitration among two or more low requests, as a rotated service order, and also when the pointer is read back. A dropped or wrong held level shows up on the acknowledge: the pointer either stays put or moves when it should not. A broken hold register shows within a few cycles as a vector change before acknowledge, with a later high request overtaking a held low one. For that reason the bench serves sequences of several requests and compares the full order, and it reads the pointer between sequences.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MED  = 2'd2,
    LVL_HIGH = 2'd3
  } level_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrPtr;
    logic take;
  } strobe_t;

endpackage

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  reqs,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqs[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_level_ctrl_unit.sv
module irq_level_ctrl_unit
  import irq_level_pkg::*;
(
  input  logic    regWrEn,
  input  logic    regAddr,
  input  logic    irqAck,
  input  logic    pendingQ,
  output strobe_t strb
);

  always_comb begin
    strb.wrCtrl = regWrEn && !regAddr;
    strb.wrPtr  = regWrEn && regAddr;
    strb.take   = irqAck && pendingQ;
  end

endmodule

// File: rtl/irq_level_dp.sv
module irq_level_dp
  import irq_level_pkg::*;
#(
  parameter int          N         = 16,
  parameter int          IW        = $clog2(N),
  parameter int          VBW       = 16,
  parameter logic [15:0] APP_BASE  = 16'h0000,
  parameter logic [15:0] BOOT_BASE = 16'h4000
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strb,
  input  logic [7:0]     wrData,
  input  logic           regAddr,
  input  logic [N-1:0]   irqReq,
  input  logic [2*N-1:0] irqLvl,
  output logic [7:0]     rdData,
  output logic           pendingQ,
  output logic [IW-1:0]  vecQ,
  output logic [VBW-1:0] vecBase
);

  logic          rrEn, vecSel;
  logic [2:0]    lvlEn;
  logic [IW-1:0] ptrQ;
  logic [1:0]    lvlQ;

  logic [N-1:0]  reqHigh, reqMed, reqLow, reqLowAbove;
  logic          fHigh, fMed, fLow, fAbove;
  logic [IW-1:0] iHigh, iMed, iLow, iAbove;
  logic          useRot, anyWin;
  logic [IW-1:0] lowIdx, winIdx;
  logic [1:0]    winLvl;

  for (genvar i = 0; i < N; i++) begin : g_split
    assign reqHigh[i]     = irqReq[i] && (irqLvl[2*i +: 2] == LVL_HIGH) && lvlEn[2];
    assign reqMed[i]      = irqReq[i] && (irqLvl[2*i +: 2] == LVL_MED)  && lvlEn[1];
    assign reqLow[i]      = irqReq[i] && (irqLvl[2*i +: 2] == LVL_LOW)  && lvlEn[0];
    assign reqLowAbove[i] = reqLow[i] && (IW'(i) > ptrQ);
  end

  irq_pick_lowest #(.N(N), .IW(IW)) i_pickHigh  (.reqs(reqHigh),     .found(fHigh),  .idx(iHigh));
  irq_pick_lowest #(.N(N), .IW(IW)) i_pickMed   (.reqs(reqMed),      .found(fMed),   .idx(iMed));
  irq_pick_lowest #(.N(N), .IW(IW)) i_pickLow   (.reqs(reqLow),      .found(fLow),   .idx(iLow));
  irq_pick_lowest #(.N(N), .IW(IW)) i_pickAbove (.reqs(reqLowAbove), .found(fAbove), .idx(iAbove));

  assign useRot = rrEn || (ptrQ != '0);
  assign lowIdx = (useRot && fAbove) ? iAbove : iLow;
  assign anyWin = fHigh || fMed || fLow;

  always_comb begin
    if (fHigh) begin
      winIdx = iHigh;  winLvl = LVL_HIGH;
    end else if (fMed) begin
      winIdx = iMed;   winLvl = LVL_MED;
    end else begin
      winIdx = lowIdx; winLvl = fLow ? LVL_LOW : LVL_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrEn   <= 1'b0;
      vecSel <= 1'b0;
      lvlEn  <= 3'b000;
    end else if (strb.wrCtrl) begin
      rrEn   <= wrData[7];
      vecSel <= wrData[6];
      lvlEn  <= wrData[2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strb.wrPtr) begin
      ptrQ <= wrData[IW-1:0];
    end else if (strb.take && rrEn && (lvlQ == LVL_LOW)) begin
      ptrQ <= vecQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      vecQ     <= '0;
      lvlQ     <= LVL_NONE;
    end else if (strb.take) begin
      pendingQ <= 1'b0;
    end else if (!pendingQ) begin
      pendingQ <= anyWin;
      vecQ     <= winIdx;
      lvlQ     <= winLvl;
    end
  end

  assign rdData  = regAddr ? 8'(ptrQ) : {rrEn, vecSel, 3'b000, lvlEn};
  assign vecBase = vecSel ? VBW'(BOOT_BASE) : VBW'(APP_BASE);

  // R10
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !strb.take) |=> (pendingQ && $stable(vecQ)));

  // R10
  drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !pendingQ);

  // R6
  ptr_follows_low_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && rrEn && (lvlQ == LVL_LOW) && !strb.wrPtr) |=> (ptrQ == $past(vecQ)));

  // R7
  ptr_kept_static_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rrEn && !strb.wrPtr) |=> $stable(ptrQ));

  // R2
  held_level_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendingQ) |-> (lvlQ != LVL_NONE));

  // R10
  idle_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pendingQ && anyWin && !strb.take) |=> pendingQ);

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_level_pkg::*;
#(
  parameter int          NUM_IRQ   = 16,
  parameter int          VB_W      = 16,
  parameter logic [15:0] APP_BASE  = 16'h0000,
  parameter logic [15:0] BOOT_BASE = 16'h4000,
  localparam int         IW        = $clog2(NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic [NUM_IRQ-1:0]   irqReq,
  input  logic [2*NUM_IRQ-1:0] irqLvl,
  input  logic                 irqAck,
  output logic                 irqPending,
  output logic [IW-1:0]        irqVector,
  output logic [VB_W-1:0]      vecBase
);

  strobe_t strb;

  irq_level_ctrl_unit i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .irqAck  (irqAck),
    .pendingQ(irqPending),
    .strb    (strb)
  );

  irq_level_dp #(
    .N(NUM_IRQ), .IW(IW), .VBW(VB_W),
    .APP_BASE(APP_BASE), .BOOT_BASE(BOOT_BASE)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .regAddr (regAddr),
    .irqReq  (irqReq),
    .irqLvl  (irqLvl),
    .rdData  (regRdData),
    .pendingQ(irqPending),
    .vecQ    (irqVector),
    .vecBase (vecBase)
  );

endmodule

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;

  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regAddr = 1'b0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic [N-1:0]  irqReq = '0;
  logic [2*N-1:0] irqLvl = '0;
  logic          irqAck = 1'b0;
  logic          irqPending;
  logic [IW-1:0] irqVector;
  logic [15:0]   vecBase;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];
  bit holdAck = 1'b1;
  int servedCnt = 0;
  int lastServed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_level_ctrl i_irq_level_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq),
    .irqLvl(irqLvl), .irqAck(irqAck), .irqPending(irqPending),
    .irqVector(irqVector), .vecBase(vecBase)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(bit a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(bit a, output int d);
    @(negedge clk);
    regAddr = a;
    #2;
    d = int'(regRdData);
  endtask

  task automatic setReq(int idx, logic [1:0] lvl);
    irqLvl[2*idx +: 2] = lvl;
    irqReq[idx] = 1'b1;
  endtask

  // Driver: queue the expected service order, release the monitor and
  // drop each request as soon as the monitor acknowledges it.
  task automatic runSeq(int n, int a, int b, int c, int d, string tag);
    int start;
    int exps[4];
    exps = '{a, b, c, d};
    for (int k = 0; k < n; k++) begin
      expQ.push_back(exps[k]);
      tagQ.push_back(tag);
    end
    start = servedCnt;
    holdAck = 1'b0;
    for (int k = 0; k < n; k++) begin
      wait (servedCnt == start + k + 1);
      irqReq[lastServed] = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each pending vector with the queue head and acknowledge.
  initial begin
    forever begin
      @(negedge clk);
      irqAck = 1'b0;
      if (irqPending && !holdAck) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected pending actual=%0d expected=none", irqVector);
        end else begin
          string t;
          int e;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, int'(irqVector), e);
        end
        lastServed = int'(irqVector);
        irqAck = 1'b1;
        servedCnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(1'b0, rd); check("R1 ctrl", rd, 0);
    readReg(1'b1, rd); check("R1 ptr", rd, 0);
    check("R1 pending", int'(irqPending), 0);
    check("R1 base", int'(vecBase), 16'h0000);

    // R3 R4 level order, static
    writeReg(1'b0, 8'h07);
    setReq(3, 2'd3); setReq(5, 2'd3); setReq(1, 2'd2); setReq(0, 2'd1);
    runSeq(4, 3, 5, 1, 0, "R3");

    // R5 static low order
    setReq(7, 2'd1); setReq(2, 2'd1); setReq(9, 2'd1);
    runSeq(3, 2, 7, 9, 0, "R5");

    // R6 rotation
    writeReg(1'b0, 8'h87);
    setReq(5, 2'd1);
    runSeq(1, 5, 0, 0, 0, "R6");
    readReg(1'b1, rd); check("R6 ptr after 5", rd, 5);
    setReq(2, 2'd1); setReq(7, 2'd1); setReq(9, 2'd1);
    runSeq(3, 7, 9, 2, 0, "R6");
    readReg(1'b1, rd); check("R6 ptr after wrap", rd, 2);

    // R4 R11 medium stays static under rotation and leaves ptr alone
    setReq(6, 2'd2); setReq(1, 2'd2);
    runSeq(2, 1, 6, 0, 0, "R4");
    readReg(1'b1, rd); check("R11 ptr after medium", rd, 2);

    // R7 R11 pointer survives rotation off
    writeReg(1'b0, 8'h07);
    readReg(1'b1, rd); check("R7 ptr kept", rd, 2);
    setReq(1, 2'd1); setReq(3, 2'd1);
    runSeq(2, 3, 1, 0, 0, "R7");
    readReg(1'b1, rd); check("R11 ptr after static ack", rd, 2);
    writeReg(1'b1, 8'h00);
    setReq(3, 2'd1); setReq(1, 2'd1);
    runSeq(2, 1, 3, 0, 0, "R7");

    // R2 disabled low level
    holdAck = 1'b1;
    writeReg(1'b0, 8'h06);
    setReq(4, 2'd1);
    repeat (5) @(negedge clk);
    check("R2 low disabled", int'(irqPending), 0);
    irqReq[4] = 1'b0;
    // R2 disabled high level
    writeReg(1'b0, 8'h03);
    setReq(0, 2'd3); setReq(8, 2'd1);
    runSeq(1, 8, 0, 0, 0, "R2");
    holdAck = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 high disabled", int'(irqPending), 0);
    irqReq[0] = 1'b0;

    // R9 R8 reserved bits and vector base
    writeReg(1'b0, 8'h38);
    readReg(1'b0, rd); check("R9 reserved only", rd, 0);
    writeReg(1'b0, 8'hFF);
    readReg(1'b0, rd); check("R9 all ones", rd, 8'hC7);
    check("R8 boot base", int'(vecBase), 16'h4000);
    writeReg(1'b0, 8'h07);
    check("R8 app base", int'(vecBase), 16'h0000);

    // R10 hold until acknowledge
    setReq(10, 2'd1);
    repeat (2) @(negedge clk);
    check("R10 pending", int'(irqPending), 1);
    check("R10 vector", int'(irqVector), 10);
    setReq(0, 2'd3);
    repeat (3) @(negedge clk);
    check("R10 held", int'(irqVector), 10);
    runSeq(2, 10, 0, 0, 0, "R10");
    check("R10 queue drained", expQ.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule